// File: doc/BRIEF.md
# Broadcast Scan Chain Configurator

This block holds the internal scan flops of a logic region as a set of equal-length segments and reshapes how they are reached from a single scan-in pin. In broadcast mode every segment takes the same bit from scan-in on each shift, so one external stream loads all segments with the same pattern at once. The segment tails are folded into a multiple-input signature register, and the signature's top bit drives scan-out. In chained mode the segments are joined end to end into one long chain from scan-in to scan-out. This tops up coverage for faults that the shared pattern cannot reach.

All segments and the signature register run on one clock. With scan enable low, every flop captures its functional input. The mode select is taken in only on those capture cycles, so the mode cannot change while a load is in progress. Pattern generation and the logic under test sit outside the block. The functional capture data comes in on a bus, and the flop contents go back out on a bus.

Top module: `scan_cfg_top`

## Requirements
- R1: While `scan_en` is 0, every flop loads its bit of `func_d` on the clock edge, with bit k*SEG_LEN+b belonging to bit b of segment k.
- R2: `mode_sel` is sampled only on edges where `scan_en` is 0 (1 = chained, 0 = broadcast). Changes of `mode_sel` while `scan_en` is 1 have no effect on the shift behaviour.
- R3: In chained mode with `scan_en` 1, the flop vector shifts one place toward the higher index on each edge, and `scan_in` enters bit 0. The last bit of segment k therefore feeds bit 0 of segment k+1.
- R4: In broadcast mode with `scan_en` 1, each segment shifts toward its higher index, and the same `scan_in` value enters bit 0 of every segment on the same edge.
- R5: In broadcast mode with `scan_en` 1, the signature updates as S' = {S[W-2:0], ^(S & 16'hB400)} XOR T. Bit k of T is the pre-shift last bit of segment k, and the higher bits of T are 0.
- R6: `scan_out` equals the last bit of the last segment in chained mode, and the signature's top bit S[W-1] in broadcast mode.
- R7: The signature holds its value on capture edges and on chained-mode shift edges.
- R8: Synchronous reset (`rst_n` 0 at an edge) clears all flops and the signature, and selects broadcast mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan and capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | 1 = shift, 0 = functional capture |
| mode_sel | input | 1 | Requested mode, 1 = chained, 0 = broadcast |
| scan_in | input | 1 | Shared scan data input |
| func_d | input | NSEG*SEG_LEN | Functional capture data |
| flop_q | output | NSEG*SEG_LEN | Current segment flop contents |
| scan_out | output | 1 | Chain tail or signature top bit |

## Verification
On every cycle, the embedded properties check four things. Capture loads the functional bus. Each segment moves by one place per shift and takes the right entry bit for the active mode. The mode stays fixed across shift cycles. The signature is frozen outside broadcast shifts and is zero after reset. Two things rest on the bench's directed scenarios, which compare against a model built from the requirements: the exact signature sequence under the fixed polynomial, and end-to-end streaming of captured data out through the full concatenated chain. The bench also shows that a mode request made mid-load is ignored.

// File: rtl/scan_cfg_pkg.sv
package scan_cfg_pkg;
    typedef enum logic {
        MODE_BCAST = 1'b0,
        MODE_CHAIN = 1'b1
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e mode;
    } ctl_t;
endpackage

// File: rtl/scan_segment.sv
module scan_segment #(
    parameter int unsigned LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic           ser_in,
    input  logic [LEN-1:0] func_d,
    output logic [LEN-1:0] seg_q
);
    logic [LEN-1:0] seg_d;

    always_comb begin
        seg_d = seg_q;
        if (cap_en) begin
            seg_d = func_d;
        end else if (shift_en) begin
            seg_d = {seg_q[LEN-2:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    // R1: capture loads the functional data
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> seg_q == $past(func_d));

    // R3 / R4: one-place shift with the entry bit at index 0
    a_r4_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !cap_en) |=> (seg_q[0] == $past(ser_in)) &&
                                  (seg_q[LEN-1:1] == $past(seg_q[LEN-2:0])));
endmodule

// File: rtl/sig_reg.sv
module sig_reg #(
    parameter int unsigned W    = 16,
    parameter int unsigned NIN  = 4,
    parameter logic [31:0] TAPS = 32'h0000_B400
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [NIN-1:0] din,
    output logic [W-1:0]   sig_q
);
    localparam logic [W-1:0] TAP_MASK = TAPS[W-1:0];

    logic [W-1:0] sig_d;
    logic [W-1:0] inj;
    logic         fb;

    always_comb begin
        inj        = '0;
        inj[NIN-1:0] = din;
        fb         = ^(sig_q & TAP_MASK);
        sig_d      = sig_q;
        if (en) sig_d = {sig_q[W-2:0], fb} ^ inj;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    // R7: signature frozen when not compacting
    a_r7_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sig_q));

    // R8: signature clear after reset
    a_r8_sig_clear: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> sig_q == '0);
endmodule

// File: rtl/scan_cfg_top.sv
module scan_cfg_top #(
    parameter int unsigned NSEG     = 4,
    parameter int unsigned SEG_LEN  = 8,
    parameter int unsigned SIG_W    = 16,
    parameter logic [31:0] SIG_TAPS = 32'h0000_B400
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_en,
    input  logic                    mode_sel,
    input  logic                    scan_in,
    input  logic [NSEG*SEG_LEN-1:0] func_d,
    output logic [NSEG*SEG_LEN-1:0] flop_q,
    output logic                    scan_out
);
    import scan_cfg_pkg::*;

    localparam int unsigned TOTAL = NSEG * SEG_LEN;

    ctl_t            ctl_d, ctl_q;
    logic [NSEG-1:0] tail;
    logic [NSEG-1:0] entry;
    logic [SIG_W-1:0] sig_q;
    logic            chained;
    logic            sig_en;

    assign chained = (ctl_q.mode == MODE_CHAIN);
    assign sig_en  = scan_en && !chained;

    always_comb begin
        ctl_d = ctl_q;
        if (!scan_en) ctl_d.mode = scan_mode_e'(mode_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{mode: MODE_BCAST};
        else        ctl_q <= ctl_d;
    end

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k == 0) begin : g_head
            assign entry[k] = scan_in;
        end else begin : g_link
            assign entry[k] = chained ? tail[k-1] : scan_in;
        end

        scan_segment #(.LEN(SEG_LEN)) i_seg (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (!scan_en),
            .shift_en (scan_en),
            .ser_in   (entry[k]),
            .func_d   (func_d[k*SEG_LEN +: SEG_LEN]),
            .seg_q    (flop_q[k*SEG_LEN +: SEG_LEN])
        );

        assign tail[k] = flop_q[k*SEG_LEN + SEG_LEN - 1];

        // R4: shared input reaches every segment head in broadcast mode
        a_r4_bcast_head: assert property (@(posedge clk) disable iff (!rst_n)
            (scan_en && !chained) |=> flop_q[k*SEG_LEN] == $past(scan_in));

        if (k > 0) begin : g_chain_chk
            // R3: segment head follows the previous segment tail
            a_r3_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
                (scan_en && chained) |=> flop_q[k*SEG_LEN] == $past(flop_q[k*SEG_LEN-1]));
        end
    end

    sig_reg #(.W(SIG_W), .NIN(NSEG), .TAPS(SIG_TAPS)) i_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sig_en),
        .din   (tail),
        .sig_q (sig_q)
    );

    assign scan_out = chained ? flop_q[TOTAL-1] : sig_q[SIG_W-1];

    // R2: mode cannot move during a shift
    a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> $stable(ctl_q.mode));

    // R8: reset selects broadcast mode
    a_r8_mode_reset: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (ctl_q.mode == MODE_BCAST) && (flop_q == '0));
endmodule

// File: tb/test_scan_cfg_top.sv
module test_scan_cfg_top;
    localparam int NSEG = 4;
    localparam int LEN  = 8;
    localparam int TOT  = NSEG * LEN;
    localparam logic [15:0] TAPS = 16'hB400;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scan_en = 1'b0;
    logic           mode_sel = 1'b0;
    logic           scan_in = 1'b0;
    logic [TOT-1:0] func_d = '0;
    logic [TOT-1:0] flop_q;
    logic           scan_out;

    int total = 0;
    int bad   = 0;

    logic [TOT-1:0] m_fl = '0;
    logic [15:0]    m_sig = '0;
    logic           m_mode = 1'b0;

    always #5 clk = ~clk;

    scan_cfg_top i_scan_cfg_top (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_sel(mode_sel),
        .scan_in(scan_in), .func_d(func_d), .flop_q(flop_q), .scan_out(scan_out)
    );

    task automatic check_state(input string tag);
        logic exp_so;
        exp_so = m_mode ? m_fl[TOT-1] : m_sig[15];
        total++;
        if (flop_q !== m_fl) begin
            bad++;
            $display("FAIL %s flop_q actual=%h expected=%h", tag, flop_q, m_fl);
        end
        total++;
        if (scan_out !== exp_so) begin
            bad++;
            $display("FAIL %s scan_out actual=%b expected=%b", tag, scan_out, exp_so);
        end
    endtask

    task automatic tick(input logic rs, input logic se, input logic ms,
                        input logic si, input logic [TOT-1:0] fd, input string tag);
        logic [TOT-1:0] old;
        logic [15:0]    inj;
        @(negedge clk);
        rst_n = rs; scan_en = se; mode_sel = ms; scan_in = si; func_d = fd;
        @(posedge clk);
        old = m_fl;
        if (!rs) begin
            m_fl = '0; m_sig = '0; m_mode = 1'b0;
        end else if (!se) begin
            m_fl = fd; m_mode = ms;
        end else if (m_mode) begin
            m_fl = {old[TOT-2:0], si};
        end else begin
            inj = '0;
            for (int k = 0; k < NSEG; k++) begin
                inj[k] = old[k*LEN + LEN - 1];
                m_fl[k*LEN +: LEN] = {old[k*LEN +: LEN-1], si};
            end
            m_sig = {m_sig[14:0], ^(m_sig & TAPS)} ^ inj;
        end
        #2;
        check_state(tag);
    endtask

    task automatic t_reset;
        tick(1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8");
        tick(1'b0, 1'b1, 1'b1, 1'b1, 32'h1234_5678, "R8");
    endtask

    task automatic t_capture;
        tick(1'b1, 1'b0, 1'b0, 1'b0, 32'hA5C3_0F96, "R1");
        tick(1'b1, 1'b0, 1'b0, 1'b1, 32'h5A3C_F069, "R1");
    endtask

    task automatic t_chain;
        tick(1'b1, 1'b0, 1'b1, 1'b0, 32'h8001_C3A7, "R1");
        for (int i = 0; i < TOT + 4; i++)
            tick(1'b1, 1'b1, 1'b1, logic'((i % 3) == 0), '0, "R3");
    endtask

    task automatic t_mode_ignored;
        for (int i = 0; i < 10; i++)
            tick(1'b1, 1'b1, logic'(i % 2), logic'((i % 4) < 2), 32'hFFFF_FFFF, "R2");
    endtask

    task automatic t_bcast;
        tick(1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, "R2");
        for (int i = 0; i < 24; i++)
            tick(1'b1, 1'b1, 1'b0, logic'((i % 5) < 2), 32'h0, "R5");
        for (int i = 0; i < 6; i++)
            tick(1'b1, 1'b1, 1'b1, logic'(i % 2), 32'h0, "R4");
    endtask

    task automatic t_hold;
        tick(1'b1, 1'b0, 1'b0, 1'b1, 32'h0F0F_3333, "R7");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 32'hF0F0_CCCC, "R7");
        tick(1'b1, 1'b0, 1'b1, 1'b0, 32'h1111_2222, "R7");
        for (int i = 0; i < 5; i++)
            tick(1'b1, 1'b1, 1'b0, 1'b1, '0, "R7");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 32'h7777_8888, "R6");
        for (int i = 0; i < 8; i++)
            tick(1'b1, 1'b1, 1'b0, logic'(i % 2), '0, "R6");
    endtask

    task automatic t_reset_mid;
        tick(1'b1, 1'b0, 1'b1, 1'b0, 32'hCAFE_F00D, "R8");
        tick(1'b0, 1'b1, 1'b1, 1'b1, '0, "R8");
        tick(1'b1, 1'b1, 1'b1, 1'b1, '0, "R8");
    endtask

    initial begin
        t_reset;
        t_capture;
        t_chain;
        t_mode_ignored;
        t_bcast;
        t_hold;
        t_reset_mid;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule